// File: doc/BRIEF.md
# Port Address Sequencer With Limit

This block holds a 5-bit read port address that advances by one on each port-step strobe. A static ports-in-use value sets the highest port the system uses. The block forms the next address (current plus one) and compares it with that value. An address beyond the limit is never produced.

When the next address would pass the limit, two things can happen. A plain step simply holds the counter. If the end-of-scan strobe falls while the next address is past the limit, a wrap request is armed. The next step then loads the counter with zero instead of incrementing it.

The block drives two copies of the address. One copy goes out with its bit weights mirrored, for the RAM address selector. The other copy goes to a minor-frame comparator. That comparator raises a registered flag when the 5-bit minor frame count equals the port address during word slot 28 of the scan.

Top module: `port_addr_seq`

## Requirements
- R1: While reset (`rst_n` low) is held and right after it, `port_addr` and `ram_addr` are 0 and `mf_match` is 0. No wrap request is pending.
- R2: A cycle with `step` high, where `port_addr`+1 is not greater than `ports_in_use`, makes `port_addr` one larger on the next clock edge. This applies when no wrap request fires.
- R3: In a cycle with `step` low, `port_addr` keeps its value. This holds even when an end-of-scan strobe arrives.
- R4: A cycle with `step` high, where `port_addr`+1 is greater than `ports_in_use` and no wrap request fires, leaves `port_addr` unchanged.
- R5: An end-of-scan termination arms a wrap request when `port_addr`+1 is greater than `ports_in_use`. A termination is a cycle where `eos` is low and `eos` was high in the cycle before. The first later `step` then loads `port_addr` with 0, and the request is cleared.
- R6: If `step` is high in the same cycle as an end-of-scan termination that meets the R5 condition, that step loads 0 at once.
- R7: An end-of-scan termination with `port_addr`+1 not greater than `ports_in_use` arms nothing. A later step that finds the limit exceeded holds, as in R4.
- R8: With `ports_in_use` equal to 0 and `port_addr` at 0, steps leave `port_addr` at 0.
- R9: `ram_addr` is `port_addr` with its bits mirrored: bit 0 with bit 4, bit 1 with bit 3, and bit 2 in place.
- R10: `mf_match` is high in the cycle after a cycle in which `word_idx` equals 28 and all 5 bits of `mf_count` equal `port_addr`. It is high for only that one cycle when `word_idx` stays at 28 for one cycle.
- R11: `mf_match` stays low when `word_idx` is not 28. It also stays low when only the low four bits of `mf_count` and `port_addr` agree and the MSBs differ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | Port-step strobe, one cycle per port slot |
| eos | input | 1 | End-of-scan strobe; its falling edge is the termination |
| word_idx | input | 5 | Current word slot within the scan |
| mf_count | input | 5 | Minor frame count |
| ports_in_use | input | 5 | Highest port number in use |
| port_addr | output | 5 | Current read port address |
| ram_addr | output | 5 | Bit-mirrored port address for the RAM path |
| mf_match | output | 1 | Registered minor-frame-equals-port flag |

## Verification
Two functions can fall in the same clock cycle: the end-of-scan termination that arms a wrap, and a port step. The bench raises `eos` for one cycle. It then drops `eos` in the very cycle that it pulses `step`, with the counter at the limit. The design is judged correct if the counter reads 0 after that edge, and not the held limit value. A second case drops `eos` below the limit, lowers the limit, and then steps. It confirms that no request was armed: the counter holds rather than wraps.

// File: rtl/pas_pkg.sv
package pas_pkg;
  localparam int ADDR_W = 5;
  localparam int WORD_W = 5;
  localparam int MATCH_WORD = 28;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [ADDR_W:0]   addr_ext_t;

  // current address plus one, one bit wider so it cannot wrap
  function automatic addr_ext_t addr_plus_one(input addr_t a);
    return {1'b0, a} + addr_ext_t'(1);
  endfunction

  // next address beyond the configured ceiling
  function automatic logic beyond_limit(input addr_t a, input addr_t lim);
    return addr_plus_one(a) > {1'b0, lim};
  endfunction

  // mirror bit weights
  function automatic addr_t mirror_bits(input addr_t a);
    addr_t r;
    for (int i = 0; i < ADDR_W; i++) r[i] = a[ADDR_W-1-i];
    return r;
  endfunction

  // low bits by equality, top bit by exclusive-or
  function automatic logic frame_equal(input addr_t a, input addr_t b);
    logic lo_eq;
    logic hi_diff;
    lo_eq   = (a[ADDR_W-2:0] == b[ADDR_W-2:0]);
    hi_diff = a[ADDR_W-1] ^ b[ADDR_W-1];
    return lo_eq & ~hi_diff;
  endfunction
endpackage

// File: rtl/pas_counter.sv
module pas_counter
  import pas_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  step,
  input  logic  eos,
  input  addr_t limit,
  output addr_t addr,
  output logic  over,
  output logic  wrap_fire,
  output logic  wrap_pend
);
  logic eos_q;
  logic eos_end;
  logic arm_now;
  addr_ext_t nxt;

  assign nxt       = addr_plus_one(addr);
  assign over      = beyond_limit(addr, limit);
  assign eos_end   = eos_q & ~eos;
  assign arm_now   = eos_end & over;
  assign wrap_fire = step & (wrap_pend | arm_now);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eos_q     <= 1'b0;
      wrap_pend <= 1'b0;
      addr      <= '0;
    end else begin
      eos_q <= eos;
      if (wrap_fire)    wrap_pend <= 1'b0;
      else if (arm_now) wrap_pend <= 1'b1;
      if (wrap_fire)          addr <= '0;
      else if (step && !over) addr <= nxt[ADDR_W-1:0];
    end
  end

  // R3
  no_step_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(addr));
  // R2
  step_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !over && !wrap_fire) |=> addr == $past(addr) + addr_t'(1));
  // R4
  limit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && over && !wrap_fire) |=> $stable(addr));
  // R5
  wrap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_fire |=> (addr == '0 && !wrap_pend));
  // R6
  same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && eos_end && over) |=> addr == '0);
endmodule

// File: rtl/pas_mf_cmp.sv
module pas_mf_cmp
  import pas_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] word_idx,
  input  addr_t             mf_count,
  input  addr_t             addr,
  output logic              match
);
  logic in_slot;
  logic equal_now;

  assign in_slot   = (word_idx == WORD_W'(MATCH_WORD));
  assign equal_now = frame_equal(mf_count, addr);

  always_ff @(posedge clk) begin
    if (!rst_n) match <= 1'b0;
    else        match <= in_slot & equal_now;
  end

  // R10
  slot_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match |-> $past(word_idx) == WORD_W'(MATCH_WORD));
  // R11
  msb_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match |-> $past(mf_count[ADDR_W-1]) == $past(addr[ADDR_W-1]));
endmodule

// File: rtl/port_addr_seq.sv
module port_addr_seq
  import pas_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              eos,
  input  logic [WORD_W-1:0] word_idx,
  input  logic [ADDR_W-1:0] mf_count,
  input  logic [ADDR_W-1:0] ports_in_use,
  output logic [ADDR_W-1:0] port_addr,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              mf_match
);
  addr_t addr_w;
  logic  over_w;
  logic  fire_w;
  logic  pend_w;

  pas_counter u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (step),
    .eos       (eos),
    .limit     (ports_in_use),
    .addr      (addr_w),
    .over      (over_w),
    .wrap_fire (fire_w),
    .wrap_pend (pend_w)
  );

  pas_mf_cmp u_cmp (
    .clk      (clk),
    .rst_n    (rst_n),
    .word_idx (word_idx),
    .mf_count (mf_count),
    .addr     (addr_w),
    .match    (mf_match)
  );

  assign port_addr = addr_w;

  for (genvar g = 0; g < ADDR_W; g++) begin : g_mirror
    assign ram_addr[g] = addr_w[ADDR_W-1-g];
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> (port_addr == '0 && !mf_match && !pend_w));
  // R9
  mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_addr == mirror_bits(port_addr));
  // R8
  zero_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ports_in_use == '0 && port_addr == '0 && !pend_w && !fire_w) |=> port_addr == '0);
  // R4
  over_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire_w && over_w && step) |=> port_addr <= $past(port_addr));
endmodule

// File: tb/tb_port_addr_seq.sv
module tb_port_addr_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       step = 1'b0;
  logic       eos = 1'b0;
  logic [4:0] word_idx = '0;
  logic [4:0] mf_count = '0;
  logic [4:0] ports_in_use = 5'd7;
  logic [4:0] port_addr;
  logic [4:0] ram_addr;
  logic       mf_match;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  port_addr_seq dut (
    .clk(clk), .rst_n(rst_n), .step(step), .eos(eos),
    .word_idx(word_idx), .mf_count(mf_count), .ports_in_use(ports_in_use),
    .port_addr(port_addr), .ram_addr(ram_addr), .mf_match(mf_match)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int mirror5(input int v);
    int r = 0;
    for (int i = 0; i < 5; i++) if (v & (1 << i)) r |= 1 << (4 - i);
    return r;
  endfunction

  task automatic do_steps(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) step = 1'b1;
      @(negedge clk) step = 1'b0;
    end
  endtask

  task automatic eos_pulse();
    @(negedge clk) eos = 1'b1;
    @(negedge clk) eos = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk); @(negedge clk);
    check("R1 port_addr", port_addr, 0);
    check("R1 mf_match", mf_match, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ram_addr", ram_addr, 0);
  endtask

  task automatic t_increment();
    do_steps(3);
    check("R2 count", port_addr, 3);
    check("R9 mirror of 3", ram_addr, mirror5(3));
  endtask

  task automatic t_hold();
    repeat (3) @(negedge clk);
    check("R3 idle hold", port_addr, 3);
  endtask

  task automatic t_saturate();
    do_steps(4);
    check("R2 reach limit", port_addr, 7);
    do_steps(2);
    check("R4 hold at limit", port_addr, 7);
  endtask

  task automatic t_wrap();
    eos_pulse();
    check("R3 armed but no step", port_addr, 7);
    do_steps(1);
    check("R5 wrap to zero", port_addr, 0);
    do_steps(1);
    check("R5 request cleared", port_addr, 1);
  endtask

  task automatic t_same_cycle();
    do_steps(6);
    check("R6 setup", port_addr, 7);
    @(negedge clk) eos = 1'b1;
    @(negedge clk) begin eos = 1'b0; step = 1'b1; end
    @(negedge clk) step = 1'b0;
    check("R6 step with termination", port_addr, 0);
  endtask

  task automatic t_no_arm();
    do_steps(2);
    eos_pulse();
    ports_in_use = 5'd2;
    do_steps(1);
    check("R7 no request armed", port_addr, 2);
    check("R9 mirror of 2", ram_addr, 8);
  endtask

  task automatic t_limit_zero();
    eos_pulse();
    do_steps(1);
    check("R5 wrap at limit 2", port_addr, 0);
    ports_in_use = 5'd0;
    do_steps(3);
    check("R8 zero limit", port_addr, 0);
  endtask

  task automatic t_match();
    ports_in_use = 5'd31;
    do_steps(21);
    check("R2 count to 21", port_addr, 21);
    check("R9 mirror of 21", ram_addr, mirror5(21));
    @(negedge clk) begin mf_count = 5'd21; word_idx = 5'd28; end
    @(negedge clk) word_idx = 5'd0;
    check("R10 match raised", mf_match, 1);
    @(negedge clk);
    check("R10 one slot only", mf_match, 0);
    @(negedge clk) begin mf_count = 5'd5; word_idx = 5'd28; end
    @(negedge clk) word_idx = 5'd0;
    check("R11 msb differs", mf_match, 0);
    @(negedge clk) begin mf_count = 5'd21; word_idx = 5'd27; end
    @(negedge clk) word_idx = 5'd0;
    check("R11 wrong word", mf_match, 0);
  endtask

  initial begin
    t_reset();
    t_increment();
    t_hold();
    t_saturate();
    t_wrap();
    t_same_cycle();
    t_no_arm();
    t_limit_zero();
    t_match();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule